// File: doc/BRIEF.md
# Atomic Read-Modify-Write Execution Unit

This unit carries out one atomic read-modify-write operation at a time against a synchronous memory port. A request gives an operation code, a width (word or doubleword), an address, an operand and the acquire/release ordering flags. The unit first asks an external extension checker whether the address is acceptable. It then checks natural alignment. After that it runs three memory phases in order: it announces the write address, reads the old value, and writes back the computed value.

When the operation succeeds, the destination register receives the value that was read, not the computed one. A reject from the checker, a misaligned address or a memory fault in any phase ends the operation with an exception code and no register write. A write-back that the memory acknowledges but reports as failed is raised as an internal error. Ordering is not enforced here. The flags derived from acquire and release are only forwarded with each memory request.

Top module: `amo_unit`

## Requirements
- R1: When atomics are disabled (`en_atomics_i`=0), or the op code is above 8, or a doubleword is requested with XLEN=32, an accepted request completes one cycle later with `done_o`=1 and `exc_code_o`=2 (illegal). No memory request is made.
- R2: In the check phase, `chk_valid_o` is raised with `chk_addr_o` equal to the request address. If `chk_reject_i` is high, the operation ends with `exc_code_o`=1 and no memory request.
- R3: If the checker accepts, an address that is not naturally aligned ends the operation with `exc_code_o`=3 and no memory request. A word is misaligned when addr[1:0]≠0, a doubleword when addr[2:0]≠0.
- R4: Memory requests are issued in the order announce (`mem_kind_o`=0), read (1), write (2). Each request is held with the same kind until `mem_ack_i`. `mem_dw_o` is 1 for doubleword and 0 for word.
- R5: The flags sent with each request (`mem_aq_o`, `mem_rl_o`) are: announce (aq&rl, rl), read (aq, aq&rl), write (aq&rl, rl).
- R6: The result is computed from the operand x and the loaded value m, by op code: 0 swap (x), 1 add (x+m), 2 xor, 3 and, 4 or, 5 signed min, 6 signed max, 7 unsigned min, 8 unsigned max.
- R7: For a word, read data arrives in `mem_rdata_i[31:0]`. It is sign-extended to XLEN before use, and the operand is taken as its low 32 bits sign-extended. Only the low 32 bits of the result are written, in `mem_wdata_o[31:0]` with the upper bits zero.
- R8: On success, `done_o`, `rd_we_o` and `rd_data_o` present the loaded value after extension for one cycle, with `exc_code_o`=0.
- R9: `mem_fault_i` together with `mem_ack_i` in any phase ends the operation with `exc_code_o`=4. No further request and no register write follow.
- R10: A write-back acknowledged with `mem_wfail_i` ends the operation with `int_err_o`=1 and no register write.
- R11: `busy_o` is high from acceptance until completion. Requests that arrive while busy are ignored. `done_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_atomics_i | input | 1 | Atomics enabled |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 4 | Operation code |
| req_dw_i | input | 1 | 1 = doubleword, 0 = word |
| req_addr_i | input | XLEN | Address |
| req_opnd_i | input | XLEN | Operand |
| req_aq_i | input | 1 | Acquire flag |
| req_rl_i | input | 1 | Release flag |
| busy_o | output | 1 | Operation in progress |
| chk_valid_o | output | 1 | Extension check request |
| chk_addr_o | output | XLEN | Address being checked |
| chk_reject_i | input | 1 | Extension rejects the address |
| mem_req_o | output | 1 | Memory request |
| mem_kind_o | output | 2 | 0 announce, 1 read, 2 write |
| mem_addr_o | output | XLEN | Memory address |
| mem_dw_o | output | 1 | Access is 8 bytes |
| mem_wdata_o | output | XLEN | Write data |
| mem_aq_o | output | 1 | Forwarded acquire flag |
| mem_rl_o | output | 1 | Forwarded release flag |
| mem_ack_i | input | 1 | Request completed |
| mem_fault_i | input | 1 | Completed request faulted |
| mem_wfail_i | input | 1 | Write completed but reported failure |
| mem_rdata_i | input | XLEN | Read data |
| done_o | output | 1 | Completion pulse |
| exc_code_o | output | 3 | 0 none, 1 extension, 2 illegal, 3 misaligned, 4 fault |
| int_err_o | output | 1 | Internal error on completion |
| rd_we_o | output | 1 | Destination write |
| rd_data_o | output | XLEN | Destination value |

## Verification
The bench builds the unit with XLEN=64. This makes both widths reachable: word operations on the upper and lower halves of a doubleword, sign extension of negative words, and signed/unsigned compare differences on full 64-bit values. A behavioural memory with a switchable one-cycle stall lets the bench exercise requests held across several cycles, and it allows requests to be poked while the unit is busy. Faults are injected separately into each of the three phases, and a failed write-back is injected on its own.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [3:0] {
    OP_SWAP = 4'd0, OP_ADD = 4'd1, OP_XOR = 4'd2, OP_AND = 4'd3, OP_OR = 4'd4,
    OP_MIN = 4'd5, OP_MAX = 4'd6, OP_MINU = 4'd7, OP_MAXU = 4'd8
  } amo_op_e;

  typedef enum logic [1:0] {
    MK_ANNOUNCE = 2'd0, MK_READ = 2'd1, MK_WRITE = 2'd2
  } mem_kind_e;

  typedef enum logic [2:0] {
    EXC_NONE = 3'd0, EXC_EXT = 3'd1, EXC_ILLEGAL = 3'd2, EXC_MISALIGN = 3'd3, EXC_FAULT = 3'd4
  } exc_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_ANNOUNCE, ST_READ, ST_WRITE
  } state_e;

  localparam int unsigned OP_LAST = 8;
endpackage

// File: rtl/amo_alu.sv
module amo_alu import amo_pkg::*; #(
  parameter int XLEN = 64
) (
  input  logic [3:0]      op_i,
  input  logic            word_i,
  input  logic [XLEN-1:0] opnd_i,
  input  logic [XLEN-1:0] loaded_i,
  output logic [XLEN-1:0] res_o
);
  logic [XLEN-1:0] opnd_x;
  logic            lt_s, lt_u;

  if (XLEN > 32) begin : g_wide
    assign opnd_x = word_i ? {{(XLEN-32){opnd_i[31]}}, opnd_i[31:0]} : opnd_i;
  end else begin : g_narrow
    logic unused_word;
    assign unused_word = word_i;
    assign opnd_x = opnd_i;
  end

  assign lt_s = $signed(opnd_x) < $signed(loaded_i);
  assign lt_u = opnd_x < loaded_i;

  always_comb begin
    unique case (amo_op_e'(op_i))
      OP_SWAP: res_o = opnd_x;
      OP_ADD:  res_o = opnd_x + loaded_i;
      OP_XOR:  res_o = opnd_x ^ loaded_i;
      OP_AND:  res_o = opnd_x & loaded_i;
      OP_OR:   res_o = opnd_x | loaded_i;
      OP_MIN:  res_o = lt_s ? opnd_x : loaded_i;
      OP_MAX:  res_o = lt_s ? loaded_i : opnd_x;
      OP_MINU: res_o = lt_u ? opnd_x : loaded_i;
      OP_MAXU: res_o = lt_u ? loaded_i : opnd_x;
      default: res_o = opnd_x;
    endcase
  end
endmodule

// File: rtl/amo_addr_chk.sv
module amo_addr_chk import amo_pkg::*; #(
  parameter int XLEN = 64
) (
  input  logic [3:0] req_op_i,
  input  logic       req_dw_i,
  input  logic [2:0] addr_lsb_i,
  input  logic       word_i,
  output logic       legal_o,
  output logic       misaligned_o
);
  localparam bit DW_OK = (XLEN == 64);

  assign legal_o      = (int'(req_op_i) <= int'(OP_LAST)) && (!req_dw_i || DW_OK);
  assign misaligned_o = word_i ? (addr_lsb_i[1:0] != 2'b00) : (addr_lsb_i != 3'b000);
endmodule

// File: rtl/amo_unit.sv
module amo_unit import amo_pkg::*; #(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_atomics_i,
  input  logic            req_valid_i,
  input  logic [3:0]      req_op_i,
  input  logic            req_dw_i,
  input  logic [XLEN-1:0] req_addr_i,
  input  logic [XLEN-1:0] req_opnd_i,
  input  logic            req_aq_i,
  input  logic            req_rl_i,
  output logic            busy_o,
  output logic            chk_valid_o,
  output logic [XLEN-1:0] chk_addr_o,
  input  logic            chk_reject_i,
  output logic            mem_req_o,
  output logic [1:0]      mem_kind_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic            mem_dw_o,
  output logic [XLEN-1:0] mem_wdata_o,
  output logic            mem_aq_o,
  output logic            mem_rl_o,
  input  logic            mem_ack_i,
  input  logic            mem_fault_i,
  input  logic            mem_wfail_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            done_o,
  output logic [2:0]      exc_code_o,
  output logic            int_err_o,
  output logic            rd_we_o,
  output logic [XLEN-1:0] rd_data_o
);
  state_e          state_q;
  logic [3:0]      op_q;
  logic            word_q, aq_q, rl_q;
  logic [XLEN-1:0] addr_q, opnd_q, loaded_q;
  logic            done_q, rd_we_q, int_err_q;
  exc_e            exc_q;
  logic [XLEN-1:0] rd_data_q;

  logic            legal, misaligned;
  logic [XLEN-1:0] rdata_ext, res;

  amo_addr_chk #(.XLEN(XLEN)) u_chk (
    .req_op_i     (req_op_i),
    .req_dw_i     (req_dw_i),
    .addr_lsb_i   (addr_q[2:0]),
    .word_i       (word_q),
    .legal_o      (legal),
    .misaligned_o (misaligned)
  );

  amo_alu #(.XLEN(XLEN)) u_alu (
    .op_i     (op_q),
    .word_i   (word_q),
    .opnd_i   (opnd_q),
    .loaded_i (loaded_q),
    .res_o    (res)
  );

  if (XLEN > 32) begin : g_rext
    assign rdata_ext = word_q ? {{(XLEN-32){mem_rdata_i[31]}}, mem_rdata_i[31:0]} : mem_rdata_i;
  end else begin : g_rnat
    assign rdata_ext = mem_rdata_i;
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign chk_valid_o = (state_q == ST_CHECK);
  assign chk_addr_o  = addr_q;
  assign mem_addr_o  = addr_q;
  assign mem_dw_o    = !word_q;
  assign mem_wdata_o = word_q ? XLEN'(res[31:0]) : res;

  always_comb begin
    mem_req_o  = 1'b0;
    mem_kind_o = MK_ANNOUNCE;
    mem_aq_o   = 1'b0;
    mem_rl_o   = 1'b0;
    unique case (state_q)
      ST_ANNOUNCE: begin
        mem_req_o = 1'b1; mem_kind_o = MK_ANNOUNCE;
        mem_aq_o = aq_q & rl_q; mem_rl_o = rl_q;
      end
      ST_READ: begin
        mem_req_o = 1'b1; mem_kind_o = MK_READ;
        mem_aq_o = aq_q; mem_rl_o = aq_q & rl_q;
      end
      ST_WRITE: begin
        mem_req_o = 1'b1; mem_kind_o = MK_WRITE;
        mem_aq_o = aq_q & rl_q; mem_rl_o = rl_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= '0;
      word_q    <= 1'b1;
      aq_q      <= 1'b0;
      rl_q      <= 1'b0;
      addr_q    <= '0;
      opnd_q    <= '0;
      loaded_q  <= '0;
      done_q    <= 1'b0;
      rd_we_q   <= 1'b0;
      int_err_q <= 1'b0;
      exc_q     <= EXC_NONE;
      rd_data_q <= '0;
    end else begin
      done_q    <= 1'b0;
      rd_we_q   <= 1'b0;
      int_err_q <= 1'b0;
      exc_q     <= EXC_NONE;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          if (!en_atomics_i || !legal) begin
            done_q <= 1'b1;
            exc_q  <= EXC_ILLEGAL;
          end else begin
            op_q    <= req_op_i;
            word_q  <= !req_dw_i;
            aq_q    <= req_aq_i;
            rl_q    <= req_rl_i;
            addr_q  <= req_addr_i;
            opnd_q  <= req_opnd_i;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (chk_reject_i) begin
            done_q <= 1'b1; exc_q <= EXC_EXT; state_q <= ST_IDLE;
          end else if (misaligned) begin
            done_q <= 1'b1; exc_q <= EXC_MISALIGN; state_q <= ST_IDLE;
          end else begin
            state_q <= ST_ANNOUNCE;
          end
        end
        ST_ANNOUNCE: if (mem_ack_i) begin
          if (mem_fault_i) begin
            done_q <= 1'b1; exc_q <= EXC_FAULT; state_q <= ST_IDLE;
          end else begin
            state_q <= ST_READ;
          end
        end
        ST_READ: if (mem_ack_i) begin
          if (mem_fault_i) begin
            done_q <= 1'b1; exc_q <= EXC_FAULT; state_q <= ST_IDLE;
          end else begin
            loaded_q <= rdata_ext;
            state_q  <= ST_WRITE;
          end
        end
        ST_WRITE: if (mem_ack_i) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
          if (mem_fault_i) begin
            exc_q <= EXC_FAULT;
          end else if (mem_wfail_i) begin
            int_err_q <= 1'b1;
          end else begin
            rd_we_q   <= 1'b1;
            rd_data_q <= loaded_q;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o     = done_q;
  assign exc_code_o = exc_q;
  assign int_err_o  = int_err_q;
  assign rd_we_o    = rd_we_q;
  assign rd_data_o  = rd_data_q;

  // R1
  illegal_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && !en_atomics_i) |=> (done_o && exc_code_o == 3'd2 && !mem_req_o));
  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_kind_o) && $stable(mem_addr_o)));
  // R5
  read_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_kind_o == 2'd1 && mem_rl_o) |-> mem_aq_o);
  // R5
  write_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_kind_o != 2'd1 && mem_aq_o) |-> mem_rl_o);
  // R8
  rd_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> (done_o && exc_code_o == 3'd0 && !int_err_o));
  // R9
  fault_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_ack_i && mem_fault_i) |=> (done_o && !rd_we_o && !mem_req_o));
  // R10
  wfail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_err_o |-> (done_o && !rd_we_o));
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/amo_unit_test.sv
module amo_unit_test;
  localparam int XLEN = 64;
  localparam time TCK = 8ns;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en_atomics, req_valid, req_dw, req_aq, req_rl;
  logic [3:0] req_op;
  logic [63:0] req_addr, req_opnd;
  logic busy, chk_valid, chk_reject, mem_req, mem_dw, mem_aq, mem_rl;
  logic mem_ack, mem_fault, mem_wfail, done, int_err, rd_we;
  logic [1:0] mem_kind;
  logic [2:0] exc_code;
  logic [63:0] chk_addr, mem_addr, mem_wdata, mem_rdata, rd_data;

  int n_chk = 0, n_bad = 0;
  int fault_ph = 0;
  bit wfail_en = 0, rej_en = 0, slow = 0, wr_hi_bad = 0, chk_addr_bad = 0;
  logic stall_r = 1'b0;
  logic [63:0] mem [16];
  logic [3:0] trace [$];

  always #(TCK/2) clk = ~clk;

  amo_unit #(.XLEN(XLEN)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_atomics_i(en_atomics),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_dw_i(req_dw),
    .req_addr_i(req_addr), .req_opnd_i(req_opnd), .req_aq_i(req_aq), .req_rl_i(req_rl),
    .busy_o(busy), .chk_valid_o(chk_valid), .chk_addr_o(chk_addr), .chk_reject_i(chk_reject),
    .mem_req_o(mem_req), .mem_kind_o(mem_kind), .mem_addr_o(mem_addr), .mem_dw_o(mem_dw),
    .mem_wdata_o(mem_wdata), .mem_aq_o(mem_aq), .mem_rl_o(mem_rl),
    .mem_ack_i(mem_ack), .mem_fault_i(mem_fault), .mem_wfail_i(mem_wfail), .mem_rdata_i(mem_rdata),
    .done_o(done), .exc_code_o(exc_code), .int_err_o(int_err), .rd_we_o(rd_we), .rd_data_o(rd_data)
  );

  // behavioural memory
  assign chk_reject = chk_valid && rej_en;
  assign mem_ack    = mem_req && !stall_r;
  assign mem_fault  = mem_ack && (fault_ph == int'(mem_kind) + 1);
  assign mem_wfail  = mem_ack && wfail_en && (mem_kind == 2'd2);

  always_comb begin
    if (mem_dw) mem_rdata = mem[mem_addr[6:3]];
    else mem_rdata = {32'h0, mem_addr[2] ? mem[mem_addr[6:3]][63:32] : mem[mem_addr[6:3]][31:0]};
  end

  always @(posedge clk) begin
    if (!mem_req) stall_r <= slow;
    else stall_r <= slow ? ~stall_r : 1'b0;
    if (chk_valid && chk_addr != req_addr) chk_addr_bad <= 1;
    if (mem_ack) begin
      trace.push_back({mem_kind, mem_aq, mem_rl});
      if (mem_kind == 2'd2 && !mem_fault && !mem_wfail) begin
        if (mem_dw) mem[mem_addr[6:3]] <= mem_wdata;
        else begin
          if (mem_wdata[63:32] != 32'h0) wr_hi_bad <= 1;
          if (mem_addr[2]) mem[mem_addr[6:3]][63:32] <= mem_wdata[31:0];
          else mem[mem_addr[6:3]][31:0] <= mem_wdata[31:0];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] ref_res(input int op, input logic [63:0] x, input logic [63:0] m);
    longint sx = longint'(x), sm = longint'(m);
    case (op)
      0: return x;
      1: return x + m;
      2: return x ^ m;
      3: return x & m;
      4: return x | m;
      5: return (sx < sm) ? x : m;
      6: return (sx > sm) ? x : m;
      7: return (x < m) ? x : m;
      default: return (x > m) ? x : m;
    endcase
  endfunction

  task automatic run(input int op, input bit dw, input logic [63:0] addr, input logic [63:0] opnd,
                     input bit aq, input bit rl, input int fph, input bit wf, input bit rej,
                     input bit slw, input bit poke, input string tag);
    logic [63:0] old64, m, x, res, new64;
    int exp_code, cyc, exp_len;
    bit ok;
    int idx = int'(addr[6:3]);
    old64 = mem[idx];
    if (dw) m = old64;
    else m = sx32(addr[2] ? old64[63:32] : old64[31:0]);
    x = dw ? opnd : sx32(opnd[31:0]);
    res = ref_res(op, x, m);
    new64 = dw ? res : (addr[2] ? {res[31:0], old64[31:0]} : {old64[63:32], res[31:0]});
    if (rej) exp_code = 1;
    else if (dw ? (addr[2:0] != 0) : (addr[1:0] != 0)) exp_code = 3;
    else if (fph != 0) exp_code = 4;
    else exp_code = 0;
    exp_len = (exp_code == 0) ? 3 : (exp_code == 4 ? fph : 0);

    trace.delete();
    fault_ph = fph; wfail_en = wf; rej_en = rej; slow = slw; wr_hi_bad = 0; chk_addr_bad = 0;
    @(negedge clk);
    en_atomics = 1; req_valid = 1; req_op = 4'(op); req_dw = dw; req_addr = addr;
    req_opnd = opnd; req_aq = aq; req_rl = rl;
    @(negedge clk);
    req_valid = 0;
    chk(busy, {tag, " R11 busy after accept"}, 64'(busy), 64'd1);
    cyc = 0;
    while (!done && cyc < 40) begin
      if (poke && cyc < 3) begin req_valid = 1; req_op = 4'hF; end
      @(negedge clk);
      req_valid = 0;
      cyc++;
    end
    req_valid = 0;
    chk(done, {tag, " done seen"}, 64'(done), 64'd1);
    chk(exc_code == 3'(exp_code), {tag, " R2 R3 R9 exc code"}, 64'(exc_code), 64'(exp_code));
    chk(trace.size() == exp_len, {tag, " R4 request count"}, 64'(trace.size()), 64'(exp_len));
    chk(!chk_addr_bad, {tag, " R2 check address"}, 64'(chk_addr_bad), 64'd0);
    ok = 1;
    foreach (trace[i]) begin
      logic [3:0] e;
      case (i)
        0: e = {2'd0, aq & rl, rl};
        1: e = {2'd1, aq, aq & rl};
        default: e = {2'd2, aq & rl, rl};
      endcase
      if (trace[i] != e) begin
        ok = 0;
        chk(0, {tag, " R4 R5 request kind/flags"}, 64'(trace[i]), 64'(e));
      end
    end
    if (ok) chk(1, "R5", 0, 0);
    if (exp_code == 0 && !wf) begin
      chk(rd_we && rd_data == m, {tag, " R6 R8 rd value"}, rd_data, m);
      chk(mem[idx] == new64, {tag, " R6 R7 memory after"}, mem[idx], new64);
      chk(!wr_hi_bad, {tag, " R7 upper write bits"}, 64'(wr_hi_bad), 64'd0);
    end else begin
      chk(!rd_we, {tag, " R9 R10 no rd write"}, 64'(rd_we), 64'd0);
      chk(mem[idx] == old64, {tag, " R9 R10 memory kept"}, mem[idx], old64);
    end
    chk(int_err == wf && exp_code == 0 || !wf, {tag, " R10 int_err"}, 64'(int_err), 64'(wf));
    @(negedge clk);
    chk(!done && !busy, {tag, " R11 single pulse, idle"}, {62'd0, done, busy}, 64'd0);
    fault_ph = 0; wfail_en = 0; rej_en = 0; slow = 0;
  endtask

  task automatic run_illegal(input bit en, input int op, input bit dw, input string tag);
    trace.delete();
    @(negedge clk);
    en_atomics = en; req_valid = 1; req_op = 4'(op); req_dw = dw; req_addr = 64'h8;
    @(negedge clk);
    req_valid = 0;
    chk(done && exc_code == 3'd2, {tag, " R1 illegal in one cycle"}, {61'd0, exc_code}, 64'd2);
    chk(trace.size() == 0 && !rd_we, {tag, " R1 no memory"}, 64'(trace.size()), 64'd0);
    en_atomics = 1;
    @(negedge clk);
  endtask

  initial begin
    #(TCK * 100000);
    n_bad++;
    $display("FAIL watchdog R11 act=%h exp=%h", 64'd1, 64'd0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    en_atomics = 1; req_valid = 0; req_op = 0; req_dw = 1; req_aq = 0; req_rl = 0;
    req_addr = 0; req_opnd = 0;
    for (int i = 0; i < 16; i++)
      mem[i] = {32'h8000_0000 + 32'(i * 7), 32'hFFFF_FFF0 - 32'(i * 3)};
    mem[3] = 64'h0000_0000_0000_0005;
    repeat (3) @(negedge clk);
    chk(!done && !busy && !mem_req && !rd_we, "R11 reset state", {60'd0, done, busy, mem_req, rd_we}, 64'd0);
    rst_ni = 1;
    @(negedge clk);

    run_illegal(0, 1, 1, "disabled");
    run_illegal(1, 9, 0, "bad op");

    run(0, 1, 64'h08, 64'h1234_5678_9ABC_DEF0, 0, 0, 0, 0, 0, 0, 0, "swap dw");
    run(1, 1, 64'h10, 64'h0000_0001_0000_0010, 1, 0, 0, 0, 0, 1, 0, "add dw aq");
    run(2, 0, 64'h18, 64'h0000_0000_F0F0_F0F0, 0, 1, 0, 0, 0, 0, 0, "xor w lo rl");
    run(3, 0, 64'h1C, 64'hFFFF_0000_0FF0_0FF0, 1, 1, 0, 0, 0, 1, 0, "and w hi aqrl");
    run(4, 1, 64'h20, 64'h0000_0000_0000_0001, 1, 1, 0, 0, 0, 0, 0, "or dw");
    run(5, 1, 64'h28, 64'h0000_0000_0000_0003, 0, 0, 0, 0, 0, 0, 0, "min dw neg");
    run(6, 1, 64'h30, 64'h0000_0000_0000_0003, 0, 0, 0, 0, 0, 0, 0, "max dw");
    run(7, 1, 64'h38, 64'h0000_0000_0000_0003, 0, 0, 0, 0, 0, 0, 0, "minu dw");
    run(8, 1, 64'h40, 64'h0000_0000_0000_0003, 0, 0, 0, 0, 0, 0, 0, "maxu dw");
    run(5, 0, 64'h18, 64'h0000_0000_0000_0002, 0, 0, 0, 0, 0, 0, 0, "R7 min w neg");
    run(6, 0, 64'h4C, 64'hFFFF_FFFF_8000_0000, 1, 0, 0, 0, 0, 0, 0, "R7 max w opnd sext");
    run(7, 0, 64'h48, 64'h0000_0000_0000_0002, 0, 0, 0, 0, 0, 0, 0, "R7 minu w");
    run(8, 0, 64'h1C, 64'h0000_0000_7FFF_FFFF, 0, 0, 0, 0, 0, 0, 0, "R7 maxu w");
    run(1, 0, 64'h18, 64'h0000_0000_0000_0040, 0, 0, 0, 0, 0, 0, 0, "R7 add w wrap");

    run(1, 1, 64'h08, 64'h1, 0, 0, 0, 0, 1, 0, 0, "R2 reject");
    run(1, 1, 64'h09, 64'h1, 0, 0, 0, 0, 1, 0, 0, "R2 reject before align");
    run(1, 1, 64'h0C, 64'h1, 0, 0, 0, 0, 0, 0, 0, "R3 dw misaligned");
    run(1, 0, 64'h0A, 64'h1, 0, 0, 0, 0, 0, 0, 0, "R3 w misaligned");
    run(1, 1, 64'h10, 64'h1, 1, 1, 1, 0, 0, 0, 0, "R9 fault announce");
    run(1, 1, 64'h10, 64'h1, 1, 0, 2, 0, 0, 1, 0, "R9 fault read");
    run(1, 0, 64'h14, 64'h1, 0, 1, 3, 0, 0, 0, 0, "R9 fault write");
    run(2, 1, 64'h20, 64'hFF, 1, 1, 0, 1, 0, 0, 0, "R10 write fail");
    run(0, 1, 64'h50, 64'hCAFE, 0, 1, 0, 0, 0, 1, 1, "R11 poke while busy");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule